// File: doc/BRIEF.md
# Multiplexed-Address DRAM Controller with Row Refresh

This block sits between a host and a single DRAM device holding 2048 rows by 2048 columns of 4-bit cells. The host presents a 22-bit word address, a write flag and write data, and holds a request line until the controller acknowledges it. The controller splits the address into an 11-bit row and an 11-bit column and sends both, one after the other, over the same 11 address pins. The row strobe opens the row, the column strobe selects the cell, and a precharge phase follows in which the sensed row is restored.

An interval timer raises a refresh request. When the controller is next idle it serves that request before any waiting host request. It runs a row-only cycle on the row named by an internal counter, which senses and writes back the whole row, and then advances the counter. Host accesses wait while a refresh is in progress.

The sequencer has five states. IDLE goes to REFRESH when a refresh is pending, or else to ROW_OPEN when a host request is present. ROW_OPEN goes to COL_ACCESS after the row-to-column delay. COL_ACCESS goes to PRECHARGE after the column time. REFRESH goes to PRECHARGE after the refresh time. PRECHARGE goes back to IDLE after the precharge time.

Top module: `dram_ctrl`

## Requirements
- R1: After reset the row and column strobes (active low) are high, `host_ack` and `host_rvalid` are low, and the refresh row counter is 0.
- R2: Host address bits [21:11] are the row and bits [10:0] are the column. The row is on `mem_addr` when `mem_ras_n` falls, and the column is on `mem_addr` when `mem_cas_n` falls.
- R3: In a host access `mem_cas_n` falls exactly T_RCD cycles after `mem_ras_n` falls and stays low for T_CAS cycles. Both strobes are then high for at least T_RP cycles before `mem_ras_n` falls again. `mem_cas_n` is never low while `mem_ras_n` is high.
- R4: In a write, `mem_we_n` is low and `mem_dq_oe` is high with the write data on `mem_dq_out` while `mem_cas_n` is low. In a read, `mem_we_n` stays high and `mem_dq_oe` stays low.
- R5: Each request gets exactly one single-cycle `host_ack` pulse. A read gets a single-cycle `host_rvalid` pulse in the same cycle, carrying the value of `mem_dq_in` from the last column cycle. A write produces no `host_rvalid`.
- R6: A refresh request is raised every REF_INTERVAL cycles. A refresh holds `mem_ras_n` low for T_REF cycles while `mem_cas_n` stays high. When the bus is idle, successive refreshes start exactly REF_INTERVAL cycles apart.
- R7: Successive refreshes address rows 0, 1, 2, ... and the row counter wraps from 2047 to 0.
- R8: If a refresh and a host request are both pending when the controller is idle, the refresh runs first. A host request that arrives during a refresh is acknowledged only after the refresh and its precharge complete.
- R9: Data written to a location is returned by a later read of the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request, held until acknowledged |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 22 | Word address, row in [21:11], column in [10:0] |
| host_wdata | input | 4 | Write data |
| host_ack | output | 1 | Single-cycle acknowledge |
| host_rvalid | output | 1 | Single-cycle read data valid |
| host_rdata | output | 4 | Read data |
| mem_addr | output | 11 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 4 | Data driven to the device |
| mem_dq_oe | output | 1 | Data output enable |
| mem_dq_in | input | 4 | Data sensed from the device |

## Verification
The bench builds the controller with T_RCD=2, T_CAS=2, T_RP=1, T_REF=3 and REF_INTERVAL=24. A 24-cycle refresh interval lets the row counter pass through all 2048 rows and wrap within about 50k cycles, which brings R7 into reach. It also makes it easy to place a host request on the exact cycle a refresh becomes pending, or on the first cycle of a refresh. With these short phases the expected acknowledge latencies are small and exact, so a wrong priority or a missing stall shows up as a latency of the wrong length.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROW_OPEN,
        ST_COL_ACCESS,
        ST_PRECHARGE,
        ST_REFRESH
    } ctrl_state_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int REF_INTERVAL = 1560
) (
    input  logic clk,
    input  logic rst_n,
    input  logic grant,
    output logic pend
);
    localparam int TW = (REF_INTERVAL > 2) ? $clog2(REF_INTERVAL) : 1;
    localparam logic [TW-1:0] RELOAD = TW'(REF_INTERVAL - 1);

    logic [TW-1:0] tick_cnt;
    logic          expire;

    assign expire = (tick_cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tick_cnt <= RELOAD;
            pend     <= 1'b0;
        end else begin
            tick_cnt <= expire ? RELOAD : tick_cnt - 1'b1;
            if (expire)
                pend <= 1'b1;
            else if (grant)
                pend <= 1'b0;
        end
    end

    assert_expire_sets_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend);
    assert_pend_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !grant) |=> pend);
endmodule

// File: rtl/dram_row_counter.sv
module dram_row_counter #(
    parameter int ROW_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] LAST = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            row <= '0;
        else if (adv)
            row <= (row == LAST) ? '0 : row + 1'b1;
    end

    assert_row_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && row == LAST) |=> (row == '0));
    assert_row_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(row));
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_pkg::*;
#(
    parameter int ROW_W        = 11,
    parameter int COL_W        = 11,
    parameter int DATA_W       = 4,
    parameter int T_RCD        = 3,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 3,
    parameter int T_REF        = 5,
    parameter int REF_INTERVAL = 1560
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_req,
    input  logic                   host_we,
    input  logic [ROW_W+COL_W-1:0] host_addr,
    input  logic [DATA_W-1:0]      host_wdata,
    output logic                   host_ack,
    output logic                   host_rvalid,
    output logic [DATA_W-1:0]      host_rdata,
    output logic [ROW_W-1:0]       mem_addr,
    output logic                   mem_ras_n,
    output logic                   mem_cas_n,
    output logic                   mem_we_n,
    output logic [DATA_W-1:0]      mem_dq_out,
    output logic                   mem_dq_oe,
    input  logic [DATA_W-1:0]      mem_dq_in
);
    localparam int T_A   = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_B   = (T_RP > T_REF) ? T_RP : T_REF;
    localparam int T_MAX = (T_A > T_B) ? T_A : T_B;
    localparam int CNT_W = $clog2(T_MAX + 1);
    localparam logic [CNT_W-1:0] LD_RCD = CNT_W'(T_RCD - 1);
    localparam logic [CNT_W-1:0] LD_CAS = CNT_W'(T_CAS - 1);
    localparam logic [CNT_W-1:0] LD_RP  = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_REF = CNT_W'(T_REF - 1);

    ctrl_state_t state, state_nx;
    logic [CNT_W-1:0]  cnt, cnt_nx;
    logic              ref_pend, ref_grant, row_adv, phase_end, accept;
    logic [ROW_W-1:0]  ref_row, lat_row;
    logic [COL_W-1:0]  lat_col;
    logic              lat_we;
    logic [DATA_W-1:0] lat_wdata;

    dram_refresh_timer #(.REF_INTERVAL(REF_INTERVAL)) u_timer (
        .clk(clk), .rst_n(rst_n), .grant(ref_grant), .pend(ref_pend));

    dram_row_counter #(.ROW_W(ROW_W)) u_rowcnt (
        .clk(clk), .rst_n(rst_n), .adv(row_adv), .row(ref_row));

    assign phase_end = (cnt == '0);
    assign ref_grant = (state == ST_IDLE) && ref_pend;
    assign accept    = (state == ST_IDLE) && !ref_pend && host_req;
    assign row_adv   = (state == ST_REFRESH) && phase_end;

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = phase_end ? cnt : cnt - 1'b1;
        unique case (state)
            ST_IDLE: begin
                if (ref_pend) begin
                    state_nx = ST_REFRESH;
                    cnt_nx   = LD_REF;
                end else if (host_req) begin
                    state_nx = ST_ROW_OPEN;
                    cnt_nx   = LD_RCD;
                end
            end
            ST_ROW_OPEN: if (phase_end) begin
                state_nx = ST_COL_ACCESS;
                cnt_nx   = LD_CAS;
            end
            ST_COL_ACCESS: if (phase_end) begin
                state_nx = ST_PRECHARGE;
                cnt_nx   = LD_RP;
            end
            ST_REFRESH: if (phase_end) begin
                state_nx = ST_PRECHARGE;
                cnt_nx   = LD_RP;
            end
            ST_PRECHARGE: if (phase_end) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register and host-side datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            cnt         <= '0;
            lat_row     <= '0;
            lat_col     <= '0;
            lat_we      <= 1'b0;
            lat_wdata   <= '0;
            host_ack    <= 1'b0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            state       <= state_nx;
            cnt         <= cnt_nx;
            host_ack    <= 1'b0;
            host_rvalid <= 1'b0;
            if (accept) begin
                lat_row   <= host_addr[ROW_W+COL_W-1:COL_W];
                lat_col   <= host_addr[COL_W-1:0];
                lat_we    <= host_we;
                lat_wdata <= host_wdata;
            end
            if (state == ST_COL_ACCESS && phase_end) begin
                host_ack <= 1'b1;
                if (!lat_we) begin
                    host_rvalid <= 1'b1;
                    host_rdata  <= mem_dq_in;
                end
            end
        end
    end

    // device pin outputs
    always_comb begin
        mem_ras_n  = 1'b1;
        mem_cas_n  = 1'b1;
        mem_we_n   = 1'b1;
        mem_dq_oe  = 1'b0;
        mem_dq_out = lat_wdata;
        mem_addr   = lat_row;
        unique case (state)
            ST_ROW_OPEN: mem_ras_n = 1'b0;
            ST_COL_ACCESS: begin
                mem_ras_n = 1'b0;
                mem_cas_n = 1'b0;
                mem_we_n  = !lat_we;
                mem_dq_oe = lat_we;
                mem_addr  = ROW_W'(lat_col);
            end
            ST_REFRESH: begin
                mem_ras_n = 1'b0;
                mem_addr  = ref_row;
            end
            default: ;
        endcase
    end

    assert_cas_inside_ras_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_cas_n |-> !mem_ras_n);
    assert_ack_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_ack |=> !host_ack);
    assert_rvalid_with_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> host_ack);
    assert_refresh_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && ref_pend) |=> (state == ST_REFRESH));
    assert_no_ack_in_refresh_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFRESH) |-> !host_ack);
    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COL_ACCESS && !phase_end) |=> $stable(mem_addr));
endmodule

// File: tb/dram_ctrl_test.sv
module dram_ctrl_test;
    localparam int T_RCD = 2, T_CAS = 2, T_RP = 1, T_REF = 3, INTERVAL = 24;

    logic clk = 1'b0, rst_n = 1'b0;
    logic host_req = 1'b0, host_we = 1'b0;
    logic [21:0] host_addr = '0;
    logic [3:0]  host_wdata = '0;
    logic host_ack, host_rvalid, mem_ras_n, mem_cas_n, mem_we_n, mem_dq_oe;
    logic [3:0] host_rdata, mem_dq_out, mem_dq_in;
    logic [10:0] mem_addr;

    always #2 clk = ~clk;

    dram_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP), .T_REF(T_REF),
                .REF_INTERVAL(INTERVAL)) uut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ack(host_ack),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata), .mem_addr(mem_addr),
        .mem_ras_n(mem_ras_n), .mem_cas_n(mem_cas_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in));

    int tests = 0, fails = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // device model
    logic [3:0]  model_mem [256];
    logic [10:0] m_row = '0, m_col = '0;
    int cyc = 0, ras_fall = 0, ras_low = 0, cas_low = 0, hi_cnt = 100, cas_gap = 0;
    bit ras_prev = 1'b1, cas_prev = 1'b1, saw_cas = 1'b0, m_oe_ok = 1'b0;
    int exp_ref = 0, ref_cnt = 0, last_ref_fall = 0;
    bit saw_wrap = 1'b0, idle_watch = 1'b0, have_last = 1'b0;

    assign mem_dq_in = model_mem[{m_row[3:0], mem_addr[3:0]}];

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!mem_ras_n && ras_prev) begin
                chk(hi_cnt >= T_RP, "R3 precharge", hi_cnt, T_RP);
                m_row = mem_addr; ras_fall = cyc; saw_cas = 0; ras_low = 0;
            end
            if (!mem_cas_n && cas_prev) begin
                m_col = mem_addr; cas_gap = cyc - ras_fall; saw_cas = 1; cas_low = 0;
                m_oe_ok = (mem_dq_oe == !mem_we_n);
                if (!mem_we_n) model_mem[{m_row[3:0], mem_addr[3:0]}] = mem_dq_out;
            end
            if (mem_cas_n && !cas_prev)
                chk(cas_low == T_CAS, "R3 cas width", cas_low, T_CAS);
            if (mem_ras_n && !ras_prev && !saw_cas) begin
                chk(m_row == exp_ref[10:0], "R7 refresh row", m_row, exp_ref);
                chk(ras_low == T_REF, "R6 refresh width", ras_low, T_REF);
                if (ref_cnt > 0 && m_row == 0) saw_wrap = 1;
                exp_ref = (exp_ref + 1) % 2048;
                ref_cnt++;
                if (idle_watch) begin
                    if (have_last)
                        chk(ras_fall - last_ref_fall == INTERVAL, "R6 interval",
                            ras_fall - last_ref_fall, INTERVAL);
                    last_ref_fall = ras_fall; have_last = 1;
                end
            end
            if (!mem_ras_n) begin ras_low++; hi_cnt = 0; end else hi_cnt++;
            if (!mem_cas_n) cas_low++;
            ras_prev = mem_ras_n; cas_prev = mem_cas_n;
        end
    end

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic access(input bit we, input logic [21:0] a, input logic [3:0] wd,
                          output logic [3:0] rd, output int lat, output bit rv);
        host_we = we; host_addr = a; host_wdata = wd; host_req = 1'b1;
        lat = 0;
        do begin tick(); lat++; end while (!host_ack && lat < 200);
        rv = host_rvalid; rd = host_rdata;
        host_req = 1'b0;
        tick();
        chk(!host_ack && !host_rvalid, "R5 single pulse", host_ack + host_rvalid, 0);
    endtask

    // {we, addr[21:0], wdata, expected}
    localparam logic [30:0] VEC [8] = '{
        {1'b1, 11'd5,    11'd9,    4'hA, 4'h0},
        {1'b1, 11'd2047, 11'd2047, 4'h5, 4'h0},
        {1'b1, 11'd0,    11'd0,    4'hF, 4'h0},
        {1'b1, 11'h013,  11'h7F3,  4'h3, 4'h0},
        {1'b0, 11'd5,    11'd9,    4'h0, 4'hA},
        {1'b0, 11'd2047, 11'd2047, 4'h0, 4'h5},
        {1'b0, 11'd0,    11'd0,    4'h0, 4'hF},
        {1'b0, 11'h013,  11'h7F3,  4'h0, 4'h3}
    };

    initial begin
        for (int i = 0; i < 256; i++) model_mem[i] = 4'h0;
        repeat (3) tick();
        chk(mem_ras_n && mem_cas_n, "R1 strobes", {mem_ras_n, mem_cas_n}, 3);
        chk(!host_ack && !host_rvalid, "R1 host outs", {host_ack, host_rvalid}, 0);
        rst_n = 1'b1;
        tick();
        chk(mem_ras_n && mem_cas_n && !host_ack, "R1 after release", mem_ras_n, 1);

        for (int i = 0; i < 8; i++) begin
            logic [3:0] rd; int lat; bit rv;
            access(VEC[i][30], VEC[i][29:8], VEC[i][7:4], rd, lat, rv);
            chk(m_row == VEC[i][29:19], "R2 row", m_row, VEC[i][29:19]);
            chk(m_col == VEC[i][18:8], "R2 col", m_col, VEC[i][18:8]);
            chk(cas_gap == T_RCD, "R3 ras-to-cas", cas_gap, T_RCD);
            chk(m_oe_ok, "R4 we/oe", m_oe_ok, 1);
            if (VEC[i][30]) chk(!rv, "R5 write no rvalid", rv, 0);
            else begin
                chk(rv, "R5 read rvalid", rv, 1);
                chk(rd == VEC[i][3:0], "R9 read data", rd, VEC[i][3:0]);
            end
        end

        // R8 stall: request on the first refresh cycle
        begin
            logic [3:0] rd; int lat; bit rv; int k;
            k = ref_cnt; while (ref_cnt == k) tick();
            repeat (INTERVAL - T_REF) tick();
            access(1'b0, {11'd5, 11'd9}, 4'h0, rd, lat, rv);
            chk(lat == T_REF + T_RP + 1 + T_RCD + T_CAS, "R8 stall latency",
                lat, T_REF + T_RP + 1 + T_RCD + T_CAS);
            chk(rd == 4'hA && rv, "R8 data after stall", rd, 10);
        end

        // R8 priority: request on the cycle the refresh becomes pending
        begin
            logic [3:0] rd; int lat; bit rv; int k;
            k = ref_cnt; while (ref_cnt == k) tick();
            k = ref_cnt;
            repeat (INTERVAL - T_REF - 1) tick();
            access(1'b1, {11'd7, 11'd7}, 4'h6, rd, lat, rv);
            chk(lat == T_REF + T_RP + 2 + T_RCD + T_CAS, "R8 refresh first",
                lat, T_REF + T_RP + 2 + T_RCD + T_CAS);
            chk(ref_cnt == k + 1, "R8 refresh ran", ref_cnt, k + 1);
            access(1'b0, {11'd7, 11'd7}, 4'h0, rd, lat, rv);
            chk(rd == 4'h6, "R9 readback", rd, 6);
        end

        // R6/R7: idle interval and full counter wrap
        idle_watch = 1'b1;
        while (!(saw_wrap && ref_cnt > 2050)) tick();
        chk(saw_wrap, "R7 wrap seen", saw_wrap, 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule